// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Fabric Scan Chains

This block is a serial test access port controller driven by a test clock, a mode-select line and a serial data input. It walks the standard sixteen-state test controller and holds a five-bit instruction. It then routes its serial output from one of several data chains: a one-bit pass-through stage, a 32-bit identification word, a 32-bit word the user supplies on a port, or a boundary register whose length is set by a parameter.

Two instructions hand the scan path to logic in the fabric. While one of them is current, the block raises a matching select line. It gates the test clock onto a per-chain data clock only during capture and shift, and it returns the chain's serial data on the output. The serial input and the reset, shift and update indications are shared by both chains. Two further instructions only raise a select level for an external configuration loader. One instruction emits a single start-up request pulse each time the controller enters its idle state. A further instruction floats every boundary output.

Top module: `jtag_tap_user`

## Requirements
- R1: The controller follows the standard sixteen-state transitions on each rising test clock edge. Five consecutive edges with mode-select high reach the reset state from any state. A low `trst_n` sampled on a rising edge forces the reset state.
- R2: In the reset state the instruction becomes the identification opcode 01001, so a data scan made without loading an instruction returns the identification word.
- R3: On entry to instruction capture the instruction shift stage loads 00001. Bits shift least significant first, and the new instruction takes effect on instruction update.
- R4: Any opcode outside the map selects a one-bit pass-through stage that captures 0. The map is: 00000 drive-test, 00001 sample/preload, 00010 user chain A, 00011 user chain B, 00100 configuration read, 00101 configuration load, 00111 internal-test, 01000 user word, 01001 identification, 01010 float, 01100 start-up, 11111 pass-through.
- R5: The identification chain is 32 bits. From the top down it holds a 4-bit version, a 7-bit family code (default 03h), a 9-bit array size, an 11-bit maker code, and a final bit fixed at 1. It shifts out least significant bit first.
- R6: The user-word instruction captures and shifts out the 32-bit `usercode` input.
- R7: Sample/preload, drive-test and internal-test capture `pad_in` into a chain of `BSR_W` bits and load it into an update register on data update. Under drive-test and internal-test `pad_out` shows the update register. Under every other instruction `pad_out` follows `core_out`.
- R8: The float instruction uses the pass-through stage and drives `pad_oe` low. Every other instruction keeps `pad_oe` high.
- R9: Under user chain A (or B), `usr_sel[0]` (or `usr_sel[1]`) is high and the serial output during data shift comes from `usr_ret[0]` (or `usr_ret[1]`). A scan of N shift cycles gives exactly N+1 rising edges on the matching `usr_dck` bit and none on the other.
- R10: `usr_tdi` follows `tdi`. `usr_reset` is high in the reset state, `usr_shift` in data shift, and `usr_update` in data update.
- R11: `tdo` and `tdo_oe` change only on falling test clock edges. `tdo_oe` is high only after a falling edge taken in instruction shift or data shift.
- R12: Configuration load raises `cfg_load_sel` and configuration read raises `cfg_read_sel`, never both at once. Both use the pass-through stage.
- R13: Under the start-up instruction, `start_req` is high for exactly the first cycle of each stay in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low reset of the controller |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | Output enable for `tdo` |
| usercode | input | 32 | Word returned by the user-word instruction |
| pad_in | input | BSR_W | Pin levels captured by the boundary chain |
| core_out | input | BSR_W | Functional values for the pins |
| pad_out | output | BSR_W | Values presented to the pins |
| pad_oe | output | 1 | Pin drive enable, low under float |
| usr_sel | output | 2 | Fabric chain selects (bit 0 chain A, bit 1 chain B) |
| usr_dck | output | 2 | Gated data clocks for the fabric chains |
| usr_ret | input | 2 | Serial return data from the fabric chains |
| usr_tdi | output | 1 | Serial data to the fabric chains |
| usr_reset | output | 1 | Controller is in the reset state |
| usr_shift | output | 1 | Controller is in data shift |
| usr_update | output | 1 | Controller is in data update |
| cfg_load_sel | output | 1 | Configuration load instruction is current |
| cfg_read_sel | output | 1 | Configuration read instruction is current |
| start_req | output | 1 | One-cycle start-up request |

## Verification
The bench builds the block with `BSR_W` = 6 and with version, array-size and maker fields that are all nonzero and differ from the defaults. The three local chain lengths (1, 6 and 32) then differ. Any wrong chain selection shows up as the wrong number of captured bits before the serial input reappears. Every identification field carries ones in the scan, so a misplaced field changes the observed word.

// File: rtl/tap_pkg.sv
// Shared types for the test access port: controller states, opcodes and
// the decoded instruction. Assumes a fixed five-bit opcode space.
package tap_pkg;

    localparam int IR_W    = 5;
    localparam int NUM_USR = 2;
    localparam int ID_W    = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00001;
    localparam logic [IR_W-1:0] OP_USR_A  = 5'b00010;
    localparam logic [IR_W-1:0] OP_USR_B  = 5'b00011;
    localparam logic [IR_W-1:0] OP_CFG_RD = 5'b00100;
    localparam logic [IR_W-1:0] OP_CFG_LD = 5'b00101;
    localparam logic [IR_W-1:0] OP_INTEST = 5'b00111;
    localparam logic [IR_W-1:0] OP_UCODE  = 5'b01000;
    localparam logic [IR_W-1:0] OP_IDCODE = 5'b01001;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b01010;
    localparam logic [IR_W-1:0] OP_START  = 5'b01100;
    localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;

    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    typedef struct packed {
        logic               bsr_cap;
        logic               bsr_drive;
        logic               highz;
        logic               id;
        logic               ucode;
        logic [NUM_USR-1:0] usr;
        logic               cfg_load;
        logic               cfg_read;
        logic               start;
    } instr_dec_t;

    // Map an opcode onto its chain and side-effect flags; unknown opcodes clear all.
    function automatic instr_dec_t decode_op(input logic [IR_W-1:0] op);
        instr_dec_t d;
        d = '0;
        case (op)
            OP_EXTEST: begin d.bsr_cap = 1'b1; d.bsr_drive = 1'b1; end
            OP_INTEST: begin d.bsr_cap = 1'b1; d.bsr_drive = 1'b1; end
            OP_SAMPLE: d.bsr_cap  = 1'b1;
            OP_USR_A:  d.usr      = 2'b01;
            OP_USR_B:  d.usr      = 2'b10;
            OP_CFG_RD: d.cfg_read = 1'b1;
            OP_CFG_LD: d.cfg_load = 1'b1;
            OP_UCODE:  d.ucode    = 1'b1;
            OP_IDCODE: d.id       = 1'b1;
            OP_HIGHZ:  d.highz    = 1'b1;
            OP_START:  d.start    = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller. Advances on rising tck; a low rst_n on a
// rising edge forces the reset state. Assumes tms is stable around the edge.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e state_q, state_d;
    logic [2:0] tms_run;

    // Next state from current state and tms.
    always_comb begin
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Saturating count of consecutive tms-high edges, used by the check below.
    always_ff @(posedge tck) begin
        if (!rst_n || !tms) tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    assign state_o = state_q;

    // R1
    tms_five_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (tms_run == 3'd5) |-> (state_q == ST_RESET));

    // R1
    reset_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_RESET && tms) |=> (state_q == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Instruction path: capture pattern, serial shift (LSB out first), update
// into the active instruction, and decode. Reset state selects identification.
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state_i,
    input  logic       tdi,
    output logic       ir_so,
    output instr_dec_t dec_o
);

    logic [IR_W-1:0] ir_sh, ir_reg;

    // Shift stage: load the capture pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                   ir_sh <= IR_CAPTURE;
        else if (state_i == ST_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state_i == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction: identification in reset, new opcode on update.
    always_ff @(posedge tck) begin
        if (!rst_n || state_i == ST_RESET) ir_reg <= OP_IDCODE;
        else if (state_i == ST_UPD_IR)     ir_reg <= ir_sh;
    end

    // Decode the active opcode.
    always_comb dec_o = decode_op(ir_reg);

    assign ir_so = ir_sh[0];

    // R2
    reset_loads_id_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_RESET) |=> (ir_reg == OP_IDCODE));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

endmodule

// File: rtl/tap_dr.sv
// Local data chains on one shared shift register whose serial entry point
// moves with the selected chain length (1, BSR_W or 32). Holds the boundary
// update register. Assumes BSR_W >= 1.
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h0000_0001
)(
    input  logic             tck,
    input  logic             rst_n,
    input  tap_state_e       state_i,
    input  logic             tdi,
    input  logic             sel_id,
    input  logic             sel_ucode,
    input  logic             sel_bsr,
    input  logic [31:0]      usercode,
    input  logic [BSR_W-1:0] pad_in,
    output logic             dr_so,
    output logic [BSR_W-1:0] bsr_upd
);

    localparam int DR_W = (BSR_W > ID_W) ? BSR_W : ID_W;
    localparam int LW   = $clog2(DR_W + 1);

    logic [DR_W-1:0] sh, sh_nxt, cap;
    logic [DR_W:0]   sh_ext;
    logic [LW-1:0]   len;

    // Length and capture value of the selected chain.
    always_comb begin
        if (sel_id || sel_ucode) len = LW'(ID_W);
        else if (sel_bsr)        len = LW'(BSR_W);
        else                     len = LW'(1);
        if (sel_id)         cap = DR_W'(ID_VALUE);
        else if (sel_ucode) cap = DR_W'(usercode);
        else if (sel_bsr)   cap = DR_W'(pad_in);
        else                cap = '0;
    end

    // One shift step: tdi enters at bit len-1, everything else moves down.
    assign sh_ext = {1'b0, sh};
    always_comb begin
        for (int i = 0; i < DR_W; i++) begin
            if (i == int'(len) - 1) sh_nxt[i] = tdi;
            else                    sh_nxt[i] = sh_ext[i+1];
        end
    end

    // Shift register: capture, shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                    sh <= '0;
        else if (state_i == ST_CAP_DR) sh <= cap;
        else if (state_i == ST_SH_DR)  sh <= sh_nxt;
    end

    // Boundary update register, loaded on data update under a boundary instruction.
    always_ff @(posedge tck) begin
        if (!rst_n)                                bsr_upd <= '0;
        else if (state_i == ST_UPD_DR && sel_bsr)  bsr_upd <= sh[BSR_W-1:0];
    end

    assign dr_so = sh[0];

endmodule

// File: rtl/jtag_tap_user.sv
// Test access port top: controller, instruction and data paths, falling-edge
// output stage, fabric chain gating, pin muxing and start-up pulse.
// Assumes usr_ret is stable around falling tck edges during data shift.
module jtag_tap_user
    import tap_pkg::*;
#(
    parameter int          BSR_W     = 16,
    parameter logic [3:0]  ID_VER    = 4'h0,
    parameter logic [6:0]  ID_FAMILY = 7'h03,
    parameter logic [8:0]  ID_ARRAY  = 9'h010,
    parameter logic [10:0] ID_MFR    = 11'h0A5
)(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [31:0]      usercode,
    input  logic [BSR_W-1:0] pad_in,
    input  logic [BSR_W-1:0] core_out,
    output logic [BSR_W-1:0] pad_out,
    output logic             pad_oe,
    output logic [1:0]       usr_sel,
    output logic [1:0]       usr_dck,
    input  logic [1:0]       usr_ret,
    output logic             usr_tdi,
    output logic             usr_reset,
    output logic             usr_shift,
    output logic             usr_update,
    output logic             cfg_load_sel,
    output logic             cfg_read_sel,
    output logic             start_req
);

    localparam logic [31:0] ID_VALUE = {ID_VER, ID_FAMILY, ID_ARRAY, ID_MFR, 1'b1};

    tap_state_e       state;
    instr_dec_t       dec;
    logic             ir_so, dr_so, shift_bit, tdo_q, tdo_oe_q, idle_seen;
    logic [BSR_W-1:0] bsr_upd;
    logic [NUM_USR-1:0] dck_en;

    tap_fsm u_fsm (.tck(tck), .rst_n(trst_n), .tms(tms), .state_o(state));

    tap_ir u_ir (.tck(tck), .rst_n(trst_n), .state_i(state), .tdi(tdi),
                 .ir_so(ir_so), .dec_o(dec));

    tap_dr #(.BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .rst_n(trst_n), .state_i(state), .tdi(tdi),
        .sel_id(dec.id), .sel_ucode(dec.ucode), .sel_bsr(dec.bsr_cap),
        .usercode(usercode), .pad_in(pad_in), .dr_so(dr_so), .bsr_upd(bsr_upd));

    // Pick the serial bit for the current shift state and instruction.
    always_comb begin
        shift_bit = dr_so;
        if (state == ST_SH_IR) shift_bit = ir_so;
        else begin
            for (int k = 0; k < NUM_USR; k++)
                if (dec.usr[k]) shift_bit = usr_ret[k];
        end
    end

    // Output stage on the falling edge, enabled only in shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_oe_q <= 1'b0;
        end else begin
            tdo_q    <= shift_bit;
            tdo_oe_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    // Per-chain clock gate: enable latched on the falling edge, gates the high phase.
    for (genvar k = 0; k < NUM_USR; k++) begin : g_usr
        always_ff @(negedge tck) begin
            if (!trst_n) dck_en[k] <= 1'b0;
            else         dck_en[k] <= dec.usr[k] &&
                                      (state == ST_CAP_DR || state == ST_SH_DR);
        end
        assign usr_dck[k] = tck & dck_en[k];

        // R9
        usr_clk_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
            dck_en[k] |-> dec.usr[k]);
    end

    // Marks that the previous cycle was already idle, for the start-up pulse.
    always_ff @(posedge tck) begin
        if (!trst_n) idle_seen <= 1'b0;
        else         idle_seen <= (state == ST_IDLE);
    end

    assign tdo          = tdo_q;
    assign tdo_oe       = tdo_oe_q;
    assign pad_out      = dec.bsr_drive ? bsr_upd : core_out;
    assign pad_oe       = !dec.highz;
    assign usr_sel      = dec.usr;
    assign usr_tdi      = tdi;
    assign usr_reset    = (state == ST_RESET);
    assign usr_shift    = (state == ST_SH_DR);
    assign usr_update   = (state == ST_UPD_DR);
    assign cfg_load_sel = dec.cfg_load;
    assign cfg_read_sel = dec.cfg_read;
    assign start_req    = dec.start && (state == ST_IDLE) && !idle_seen;

    // R11
    tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe_q == (state == ST_SH_IR || state == ST_SH_DR));

    // R13
    start_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
        start_req |=> !start_req);

endmodule

// File: tb/jtag_tap_user_bench.sv
module jtag_tap_user_bench;

    localparam int          BW    = 6;
    localparam logic [31:0] IDV   = {4'hA, 7'h03, 9'h0C3, 11'h2B5, 1'b1};
    localparam logic [31:0] UCODE = 32'hC0DE_5A17;
    localparam logic [BW-1:0] PADV = 6'b110010;
    localparam logic [BW-1:0] CORE = 6'b011011;
    localparam logic [63:0] PAT   = 64'h0000_009B_3C5A_E17D;

    localparam int NV = 12;
    localparam logic [4:0]  V_OP  [NV] = '{5'b01001, 5'b01000, 5'b11111, 5'b10110,
                                           5'b00110, 5'b01010, 5'b00001, 5'b00000,
                                           5'b00111, 5'b00101, 5'b00100, 5'b01100};
    localparam int          V_LEN [NV] = '{32, 32, 1, 1, 1, 1, BW, BW, BW, 1, 1, 1};
    localparam logic [31:0] V_CAP [NV] = '{IDV, UCODE, 32'd0, 32'd0, 32'd0, 32'd0,
                                           32'(PADV), 32'(PADV), 32'(PADV),
                                           32'd0, 32'd0, 32'd0};

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, pad_oe, usr_tdi, usr_reset, usr_shift, usr_update;
    logic cfg_load_sel, cfg_read_sel, start_req;
    logic [BW-1:0] pad_out;
    logic [1:0] usr_sel, usr_dck, usr_ret = 2'b00;

    int checks = 0, errors = 0;
    int dck0_cnt = 0, dck1_cnt = 0;
    logic [4:0]  ir_out;
    logic [63:0] dout;
    logic        o, oe_s;

    jtag_tap_user #(.BSR_W(BW), .ID_VER(4'hA), .ID_ARRAY(9'h0C3), .ID_MFR(11'h2B5))
    u_jtag_tap_user (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .usercode(UCODE), .pad_in(PADV), .core_out(CORE), .pad_out(pad_out),
        .pad_oe(pad_oe), .usr_sel(usr_sel), .usr_dck(usr_dck), .usr_ret(usr_ret),
        .usr_tdi(usr_tdi), .usr_reset(usr_reset), .usr_shift(usr_shift),
        .usr_update(usr_update), .cfg_load_sel(cfg_load_sel),
        .cfg_read_sel(cfg_read_sel), .start_req(start_req));

    always #10 tck = ~tck;

    always @(posedge usr_dck[0]) dck0_cnt++;
    always @(posedge usr_dck[1]) dck1_cnt++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One tck cycle: sample tdo after the falling edge, drive tms/tdi, pass the rising edge.
    task automatic step(input logic m, input logic d, output logic so);
        @(negedge tck); #2;
        so = tdo; oe_s = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #2;
    endtask

    task automatic load_ir(input logic [4:0] op);
        logic b;
        step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, op[i], b);
            ir_out[i] = b;
        end
        step(1, 0, b); step(0, 0, b);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] q);
        logic b;
        q = '0;
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], b);
            q[i] = b;
        end
        step(1, 0, b); step(0, 0, b);
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic b;
        // Reset state
        repeat (3) @(posedge tck);
        #2 trst_n = 1'b1;
        chk("R1 reset state", usr_reset, 1);
        chk("R11 oe after reset", tdo_oe, 0);
        chk("R9 sel after reset", usr_sel, 0);
        chk("R8 pad_oe after reset", pad_oe, 1);
        chk("R13 start after reset", start_req, 0);
        step(0, 0, b);
        scan_dr(32, 64'd0, dout);
        chk("R2 id without IR load", dout[31:0], IDV);
        chk("R11 oe idle", tdo_oe, 0);

        // Vector table: captured value, then the serial input after len bits.
        for (int v = 0; v < NV; v++) begin
            load_ir(V_OP[v]);
            chk("R3 ir capture", ir_out, 5'b00001);
            scan_dr(V_LEN[v] + 8, PAT, dout);
            chk($sformatf("R4 R5 R6 R7 vector %0d capture", v),
                dout & ((64'd1 << V_LEN[v]) - 64'd1), 64'(V_CAP[v]));
            chk($sformatf("R4 vector %0d length", v), (dout >> V_LEN[v]) & 64'hFF, PAT & 64'hFF);
        end

        // R7 preload then drive
        load_ir(5'b00001);
        scan_dr(BW, 64'b101101, dout);
        chk("R7 sample keeps core", pad_out, CORE);
        load_ir(5'b00000);
        chk("R7 drive shows update", pad_out, 6'b101101);
        chk("R8 drive keeps oe", pad_oe, 1);
        load_ir(5'b00111);
        chk("R7 internal-test shows update", pad_out, 6'b101101);
        load_ir(5'b01010);
        chk("R8 float", pad_oe, 0);
        load_ir(5'b11111);
        chk("R8 oe back", pad_oe, 1);
        chk("R7 bypass core", pad_out, CORE);

        // R12 configuration selects
        load_ir(5'b00101);
        chk("R12 load sel", {cfg_load_sel, cfg_read_sel}, 2'b10);
        load_ir(5'b00100);
        chk("R12 read sel", {cfg_load_sel, cfg_read_sel}, 2'b01);

        // R13 start-up pulse
        load_ir(5'b01100);
        chk("R13 pulse first idle", start_req, 1);
        step(0, 0, b);
        chk("R13 pulse ends", start_req, 0);

        // R9 R10 user chain A
        load_ir(5'b00010);
        chk("R9 sel A", usr_sel, 2'b01);
        usr_ret = 2'b01;
        dck0_cnt = 0; dck1_cnt = 0;
        step(1, 0, b); step(0, 0, b); step(0, 1, b);
        chk("R10 shift flag", usr_shift, 1);
        chk("R10 tdi forward", usr_tdi, 1);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, 0, b);
            chk("R9 chain A return", b, 1);
            if (i == 3) chk("R11 oe in shift", oe_s, 1);
        end
        step(1, 0, b);
        chk("R10 update flag", usr_update, 1);
        step(0, 0, b);
        chk("R9 chain A clocks", dck0_cnt, 9);
        chk("R9 chain B idle", dck1_cnt, 0);

        // R9 R11 user chain B, tdo moves only on the falling edge
        load_ir(5'b00011);
        chk("R9 sel B", usr_sel, 2'b10);
        usr_ret = 2'b00;
        dck0_cnt = 0; dck1_cnt = 0;
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        step(0, 0, b);
        chk("R9 chain B return low", b, 0);
        usr_ret = 2'b10;
        #2 chk("R11 tdo holds until fall", tdo, 0);
        step(0, 0, b);
        chk("R11 tdo after fall", b, 1);
        step(1, 0, b); step(1, 0, b); step(0, 0, b);
        chk("R9 chain B clocks", dck1_cnt, 4);
        chk("R9 chain A idle", dck0_cnt, 0);

        // R1 five tms-high edges from data shift
        load_ir(5'b11111);
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 5; i++) step(1, 0, b);
        chk("R1 five high reach reset", usr_reset, 1);
        chk("R10 reset flag", usr_reset, 1);
        step(0, 0, b);
        scan_dr(32, 64'd0, dout);
        chk("R2 id after tms reset", dout[31:0], IDV);

        // R1 synchronous reset overrides tms
        load_ir(5'b00010);
        trst_n = 1'b0;
        step(0, 0, b);
        trst_n = 1'b1;
        chk("R1 trst forces reset", usr_reset, 1);
        chk("R2 trst clears user sel", usr_sel, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule